// File: doc/BRIEF.md
# Interrupt Enable and Pending Controller

This block manages a bank of interrupt lines, 32 of them by default. Each line has an enable bit and a pending bit. The enables are programmed over a small memory-mapped register bus. One register sets enables and a second register clears them, and each acts only where a 1 is written. A line's input is level-sensitive and is sampled on every rising clock edge. A sampled high marks the line pending whether or not the line is enabled. The pending bit then stays set until the line is acknowledged.

Among the lines that are both pending and enabled, the lowest-numbered one is offered to the core as an activation request, with a valid flag and a line index. An acknowledge pulse clears the pending bit of the offered line.

Every bus access is checked before it can do anything. An access made without privilege fails, and so does an access that is not a full aligned word. A failed access returns a bus error and leaves all state unchanged.

Top module: `irq_enable_ctrl`

## Requirements
- R1: After reset every enable bit and every pending bit is 0, `act_valid` is 0 and `rsp_valid` is 0.
- R2: A privileged word write to offset 0x100 (the set register) sets enable bit n for every data bit n that is 1. Data bits that are 0 leave their enables unchanged.
- R3: A privileged word read of offset 0x100 or of offset 0x180 returns the enable vector, with bit n equal to line n's enable.
- R4: A privileged word write to offset 0x180 (the clear register) clears enable bit n for every data bit n that is 1. No write to the set register ever clears an enable.
- R5: A line whose input is sampled high becomes pending even while it is disabled. A disabled line never drives `act_valid`, and if it is enabled later its held pending state is then offered.
- R6: A pending bit stays set after its input returns low, until that line is acknowledged.
- R7: When `act_valid` is 1, `act_idx` is the lowest line number that is both pending and enabled. When no line is both pending and enabled, `act_valid` is 0.
- R8: `act_ack` high with `act_valid` high clears the pending bit of line `act_idx` at that clock edge. If the line's input is high at the same edge, the line stays pending.
- R9: An access with `req_priv` low returns `rsp_err`=1 and `rsp_rdata`=0, and does not change any enable.
- R10: An access whose address has bits [1:0] not equal to 0, or whose `req_size` is not 2 (word; 0 is byte, 1 is halfword), returns `rsp_err`=1 and `rsp_rdata`=0, and does not change any enable.
- R11: Each access with `req_valid` high is answered by `rsp_valid` in the following cycle, and a write takes effect at the same clock edge. An access to an unmapped offset answers with `rsp_rdata`=0 and `rsp_err`=0, and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NUM_LINES | Level-sensitive interrupt inputs, one per line |
| req_valid | input | 1 | Bus access strobe, one cycle per access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| req_priv | input | 1 | 1 when the access is made in privileged mode |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after `req_valid` |
| rsp_err | output | 1 | Bus error for the answered access |
| rsp_rdata | output | DATA_W | Read data for the answered access |
| act_valid | output | 1 | An enabled pending line is being offered |
| act_idx | output | IDX_W | Number of the offered line |
| act_ack | input | 1 | Acknowledge pulse for the offered line |

## Verification
A corrupted enable bit shows up on the response data of the very next read of either enable offset. Without a read, it shows at `act_valid`/`act_idx` in the same cycle that the line is next pending. A lost or stuck pending bit is exposed by the activation outputs. It appears either as soon as its line is enabled or as soon as the lines below it are acknowledged.

A faulty access check appears one cycle after the request, as a wrong `rsp_err`. It also appears as a changed enable vector on the read that follows. For that reason the bench places a read-back directly after each rejected or unmapped write.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   // Encoding of the bus access size field
   typedef enum logic [1:0] {
      XSZ_BYTE = 2'd0,
      XSZ_HALF = 2'd1,
      XSZ_WORD = 2'd2,
      XSZ_RSVD = 2'd3
   } xfer_size_e;

   // Register targeted by an access
   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_SET  = 2'd1,
      TGT_CLR  = 2'd2
   } reg_target_e;

   // Result of checking one access
   typedef struct packed {
      logic        fault;
      logic        rd_hit;
      logic        set_we;
      logic        clr_we;
      reg_target_e tgt;
   } access_dec_t;

endpackage

// File: rtl/irqc_access_gate.sv
module irqc_access_gate
   import irqc_pkg::*;
#(
   parameter int unsigned          ADDR_W  = 12,
   parameter logic [ADDR_W-1:0]    SET_OFS = 'h100,
   parameter logic [ADDR_W-1:0]    CLR_OFS = 'h180
) (
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic              req_priv,
   output access_dec_t       dec
);

   if (ADDR_W < 3) begin : g_bad_addr_w
      $error("irqc_access_gate: ADDR_W must be at least 3");
   end
   if (SET_OFS[1:0] != 2'b00 || CLR_OFS[1:0] != 2'b00) begin : g_bad_align
      $error("irqc_access_gate: register offsets must be word aligned");
   end
   if (SET_OFS == CLR_OFS) begin : g_bad_overlap
      $error("irqc_access_gate: set and clear offsets must differ");
   end

   logic        misaligned;
   logic        unpriv;
   reg_target_e tgt;

   always_comb begin
      misaligned = (req_addr[1:0] != 2'b00) || (xfer_size_e'(req_size) != XSZ_WORD);
      unpriv     = !req_priv;
      if (req_addr == SET_OFS)      tgt = TGT_SET;
      else if (req_addr == CLR_OFS) tgt = TGT_CLR;
      else                          tgt = TGT_NONE;
   end

   always_comb begin
      dec        = '0;
      dec.tgt    = tgt;
      dec.fault  = req_valid && (misaligned || unpriv);
      dec.set_we = req_valid && req_write && !dec.fault && (tgt == TGT_SET);
      dec.clr_we = req_valid && req_write && !dec.fault && (tgt == TGT_CLR);
      dec.rd_hit = req_valid && !req_write && !dec.fault && (tgt != TGT_NONE);
   end

endmodule

// File: rtl/irqc_line_bank.sv
module irqc_line_bank #(
   parameter int unsigned NUM_LINES = 32,
   parameter int unsigned IDX_W     = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_we,
   input  logic                 clr_we,
   input  logic [NUM_LINES-1:0] wmask,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic                 ack_fire,
   input  logic [IDX_W-1:0]     ack_idx,
   output logic [NUM_LINES-1:0] en_q,
   output logic [NUM_LINES-1:0] pend_q
);

   if (NUM_LINES < 1) begin : g_bad_lines
      $error("irqc_line_bank: NUM_LINES must be at least 1");
   end
   if ((2 ** IDX_W) < NUM_LINES) begin : g_bad_idx
      $error("irqc_line_bank: IDX_W too narrow for NUM_LINES");
   end

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);

      logic ack_here;
      assign ack_here = ack_fire && (ack_idx == MY_IDX);

      // enable: only the clear register can drop it
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    en_q[i] <= 1'b0;
         else if (clr_we && wmask[i])   en_q[i] <= 1'b0;
         else if (set_we && wmask[i])   en_q[i] <= 1'b1;
      end

      // pending: a sampled high input wins over an acknowledge
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         pend_q[i] <= 1'b0;
         else if (irq_in[i]) pend_q[i] <= 1'b1;
         else if (ack_here)  pend_q[i] <= 1'b0;
      end

      assert_enable_clear_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(en_q[i]) |-> $past(clr_we && wmask[i]));

      assert_enable_set_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(en_q[i]) |-> $past(set_we && wmask[i]));

      assert_pending_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(pend_q[i]) |-> $past(ack_fire && (ack_idx == MY_IDX) && !irq_in[i]));

      assert_pending_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
         irq_in[i] |=> pend_q[i]);
   end

endmodule

// File: rtl/irqc_fixed_arbiter.sv
module irqc_fixed_arbiter #(
   parameter int unsigned NUM_LINES = 32,
   parameter int unsigned IDX_W     = 5,
   parameter int unsigned ARB_STYLE = 0   // 0: priority scan, 1: isolate lowest bit then encode
) (
   input  logic [NUM_LINES-1:0] req,
   output logic                 grant_valid,
   output logic [IDX_W-1:0]     grant_idx
);

   if (ARB_STYLE > 1) begin : g_bad_style
      $error("irqc_fixed_arbiter: ARB_STYLE must be 0 or 1");
   end

   if (ARB_STYLE == 0) begin : g_scan
      always_comb begin
         grant_valid = 1'b0;
         grant_idx   = '0;
         for (int k = NUM_LINES - 1; k >= 0; k--) begin
            if (req[k]) begin
               grant_valid = 1'b1;
               grant_idx   = IDX_W'(k);
            end
         end
      end
   end else begin : g_onehot
      logic [NUM_LINES-1:0] lowest;
      always_comb begin
         lowest      = req & (~req + NUM_LINES'(1));
         grant_valid = |req;
         grant_idx   = '0;
         for (int k = 0; k < NUM_LINES; k++) begin
            if (lowest[k]) grant_idx = grant_idx | IDX_W'(k);
         end
      end
   end

endmodule

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned       NUM_LINES = 32,
   parameter int unsigned       DATA_W    = 32,
   parameter int unsigned       ADDR_W    = 12,
   parameter logic [ADDR_W-1:0] SET_OFS   = 'h100,
   parameter logic [ADDR_W-1:0] CLR_OFS   = 'h180,
   parameter int unsigned       ARB_STYLE = 0,
   localparam int unsigned      IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [1:0]           req_size,
   input  logic                 req_priv,
   input  logic [DATA_W-1:0]    req_wdata,
   output logic                 rsp_valid,
   output logic                 rsp_err,
   output logic [DATA_W-1:0]    rsp_rdata,
   output logic                 act_valid,
   output logic [IDX_W-1:0]     act_idx,
   input  logic                 act_ack
);

   if (NUM_LINES < 1 || NUM_LINES > DATA_W) begin : g_bad_lines
      $error("irq_enable_ctrl: NUM_LINES must be within 1..DATA_W");
   end
   if (DATA_W != 32) begin : g_bad_data_w
      $error("irq_enable_ctrl: word accesses assume DATA_W of 32");
   end

   access_dec_t          dec;
   logic [NUM_LINES-1:0] en_q;
   logic [NUM_LINES-1:0] pend_q;
   logic [NUM_LINES-1:0] ready_vec;
   logic                 ack_fire;
   logic [DATA_W-1:0]    rd_word;

   irqc_access_gate #(
      .ADDR_W  (ADDR_W),
      .SET_OFS (SET_OFS),
      .CLR_OFS (CLR_OFS)
   ) u_gate (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_size  (req_size),
      .req_priv  (req_priv),
      .dec       (dec)
   );

   assign ack_fire = act_ack && act_valid;

   irqc_line_bank #(
      .NUM_LINES (NUM_LINES),
      .IDX_W     (IDX_W)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_we   (dec.set_we),
      .clr_we   (dec.clr_we),
      .wmask    (req_wdata[NUM_LINES-1:0]),
      .irq_in   (irq_in),
      .ack_fire (ack_fire),
      .ack_idx  (act_idx),
      .en_q     (en_q),
      .pend_q   (pend_q)
   );

   assign ready_vec = en_q & pend_q;

   irqc_fixed_arbiter #(
      .NUM_LINES (NUM_LINES),
      .IDX_W     (IDX_W),
      .ARB_STYLE (ARB_STYLE)
   ) u_arb (
      .req         (ready_vec),
      .grant_valid (act_valid),
      .grant_idx   (act_idx)
   );

   always_comb begin
      rd_word = '0;
      if (dec.rd_hit) rd_word[NUM_LINES-1:0] = en_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= dec.fault;
         rsp_rdata <= rd_word;
      end
   end

   assert_unpriv_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_priv) |=> (rsp_err && rsp_rdata == '0 && $stable(en_q)));

   assert_misalign_error_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_addr[1:0] != 2'b00 || req_size != 2'd2)) |=> (rsp_err && $stable(en_q)));

   assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_rsp_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   assert_offer_is_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid |-> (en_q[act_idx] && pend_q[act_idx]));

   assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid |-> ((ready_vec & ~({NUM_LINES{1'b1}} << act_idx)) == '0));

   assert_idle_when_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_vec == '0) |-> !act_valid);

endmodule

// File: tb/irq_enable_ctrl_test.sv
module irq_enable_ctrl_test;

   localparam int N     = 32;
   localparam int AW    = 12;
   localparam int IW    = 5;
   localparam logic [AW-1:0] A_SET = 12'h100;
   localparam logic [AW-1:0] A_CLR = 12'h180;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_in = '0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [1:0]    req_size = 2'd2;
   logic          req_priv = 1'b1;
   logic [31:0]   req_wdata = '0;
   logic          rsp_valid;
   logic          rsp_err;
   logic [31:0]   rsp_rdata;
   logic          act_valid;
   logic [IW-1:0] act_idx;
   logic          act_ack = 1'b0;

   int total = 0;
   int bad   = 0;
   logic [N-1:0] en_m = '0;   // expected enable vector

   typedef struct {
      logic        err;
      logic [31:0] rd;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #2 clk = ~clk;   // 250 MHz

   irq_enable_ctrl uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_size(req_size), .req_priv(req_priv), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .act_valid(act_valid), .act_idx(act_idx), .act_ack(act_ack)
   );

   // monitor: pop and compare each response
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         total++;
         if (sb.size() == 0) begin
            bad++;
            $display("FAIL R11 unexpected response actual=err%0b/%h expected=none", rsp_err, rsp_rdata);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (rsp_err !== e.err || rsp_rdata !== e.rd) begin
               bad++;
               $display("FAIL %s actual=err%0b/%h expected=err%0b/%h", e.tag, rsp_err, rsp_rdata, e.err, e.rd);
            end
         end
      end
   end

   task automatic bus_op(input logic wr, input logic [AW-1:0] a, input logic [1:0] sz,
                         input logic pv, input logic [31:0] wd,
                         input logic xerr, input logic [31:0] xrd, input string tag);
      exp_t e;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
      req_priv = pv; req_wdata = wd;
      e.err = xerr; e.rd = xrd; e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_priv = 1'b1; req_size = 2'd2;
   endtask

   task automatic reg_write(input logic [AW-1:0] a, input logic [31:0] v, input string tag);
      bus_op(1'b1, a, 2'd2, 1'b1, v, 1'b0, 32'h0, tag);
      if (a == A_SET) en_m = en_m | v;
      else if (a == A_CLR) en_m = en_m & ~v;
   endtask

   task automatic reg_read(input logic [AW-1:0] a, input string tag);
      bus_op(1'b0, a, 2'd2, 1'b1, 32'h0, 1'b0,
             (a == A_SET || a == A_CLR) ? en_m : 32'h0, tag);
   endtask

   task automatic check_act(input logic xv, input logic [IW-1:0] xi, input string tag);
      total++;
      if (act_valid !== xv || (xv && act_idx !== xi)) begin
         bad++;
         $display("FAIL %s actual=%0b/%0d expected=%0b/%0d", tag, act_valid, act_idx, xv, xi);
      end
   endtask

   task automatic pulse_irq(input logic [N-1:0] m);
      @(negedge clk); irq_in = irq_in | m;
      @(negedge clk); irq_in = irq_in & ~m;
   endtask

   task automatic do_ack();
      @(negedge clk); act_ack = 1'b1;
      @(negedge clk); act_ack = 1'b0;
   endtask

   task automatic finish_run();
      total++;
      if (sb.size() != 0) begin
         bad++;
         $display("FAIL R11 missing responses actual=%0d expected=0", sb.size());
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      total++;
      if (act_valid !== 1'b0 || rsp_valid !== 1'b0) begin
         bad++;
         $display("FAIL R1 reset outputs actual=%0b/%0b expected=0/0", act_valid, rsp_valid);
      end
      rst_n = 1'b1;
      reg_read(A_SET, "R1 enables zero after reset");

      // R2, R3: set register and both read views
      reg_write(A_SET, 32'h0000_00F0, "R2 set write");
      reg_read(A_SET, "R3 read set view");
      reg_read(A_CLR, "R3 read clear view");
      reg_write(A_SET, 32'h0000_0000, "R2 zero write");
      reg_read(A_SET, "R2 zeros have no effect");
      reg_write(A_SET, 32'hA000_0001, "R2 second set write");
      reg_read(A_CLR, "R3 merged enables");

      // R4: clear register
      reg_write(A_CLR, 32'h0000_0010, "R4 clear write");
      reg_read(A_SET, "R4 only bit 4 cleared");

      // R9: unprivileged accesses
      bus_op(1'b1, A_SET, 2'd2, 1'b0, 32'hFFFF_0000, 1'b1, 32'h0, "R9 unpriv set write");
      reg_read(A_SET, "R9 enables unchanged after unpriv set");
      bus_op(1'b1, A_CLR, 2'd2, 1'b0, 32'hFFFF_FFFF, 1'b1, 32'h0, "R9 unpriv clear write");
      bus_op(1'b0, A_SET, 2'd2, 1'b0, 32'h0, 1'b1, 32'h0, "R9 unpriv read");
      reg_read(A_SET, "R9 enables unchanged after unpriv clear");

      // R10: misaligned address and size
      bus_op(1'b1, A_SET + 12'h1, 2'd2, 1'b1, 32'hFFFF_FFFF, 1'b1, 32'h0, "R10 offset addr");
      bus_op(1'b1, A_SET, 2'd1, 1'b1, 32'hFFFF_FFFF, 1'b1, 32'h0, "R10 halfword size");
      bus_op(1'b1, A_CLR, 2'd0, 1'b1, 32'hFFFF_FFFF, 1'b1, 32'h0, "R10 byte size");
      bus_op(1'b0, A_CLR + 12'h2, 2'd2, 1'b1, 32'h0, 1'b1, 32'h0, "R10 misaligned read");
      reg_read(A_SET, "R10 enables unchanged");

      // R11: unmapped offsets
      reg_read(12'h140, "R11 unmapped read");
      bus_op(1'b1, 12'h200, 2'd2, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0, "R11 unmapped write");
      reg_read(A_CLR, "R11 enables unchanged after unmapped write");

      // R5/R6: disabled line pends silently
      reg_write(A_CLR, 32'hFFFF_FFFF, "R4 clear all");
      reg_read(A_SET, "R4 all cleared");
      check_act(1'b0, 5'd0, "R7 idle with nothing enabled");
      pulse_irq(32'h0000_0008);
      check_act(1'b0, 5'd0, "R5 disabled line not offered");
      repeat (3) @(negedge clk);
      check_act(1'b0, 5'd0, "R5 still not offered");
      reg_write(A_SET, 32'h0000_0008, "R5 enable line 3");
      check_act(1'b1, 5'd3, "R6 held pending offered on enable");
      reg_write(A_CLR, 32'h0000_0008, "R5 disable line 3 again");
      check_act(1'b0, 5'd0, "R5 offer withdrawn on disable");
      reg_write(A_SET, 32'h0000_0008, "R5 re-enable line 3");
      check_act(1'b1, 5'd3, "R6 pending survived disable");

      // R7/R8: fixed priority and acknowledge
      reg_write(A_SET, 32'h0000_0202, "R7 enable lines 1 and 9");
      pulse_irq(32'h0000_0200);
      check_act(1'b1, 5'd3, "R7 line 3 beats line 9");
      pulse_irq(32'h0000_0002);
      check_act(1'b1, 5'd1, "R7 line 1 beats line 3");
      pulse_irq(32'h0000_0010);
      check_act(1'b1, 5'd1, "R7 disabled line 4 ignored");
      do_ack();
      check_act(1'b1, 5'd3, "R8 ack clears line 1");
      do_ack();
      check_act(1'b1, 5'd9, "R8 ack clears line 3");
      do_ack();
      check_act(1'b0, 5'd0, "R8 ack clears line 9");

      // R8: input still high when acknowledged
      reg_write(A_SET, 32'h0000_0020, "R8 enable line 5");
      @(negedge clk); irq_in[5] = 1'b1;
      @(negedge clk);
      check_act(1'b1, 5'd5, "R8 line 5 offered");
      do_ack();
      check_act(1'b1, 5'd5, "R8 high input re-pends");
      irq_in[5] = 1'b0;
      do_ack();
      check_act(1'b0, 5'd0, "R8 cleared after input low");

      // R7: line 4 pending since earlier, enable exposes it
      reg_write(A_SET, 32'h8000_0010, "R7 enable lines 4 and 31");
      check_act(1'b1, 5'd4, "R7 held line 4 offered");
      do_ack();
      pulse_irq(32'h8000_0000);
      check_act(1'b1, 5'd31, "R7 top line offered");
      do_ack();
      check_act(1'b0, 5'd0, "R8 all drained");
      reg_read(A_SET, "R3 final enables");

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule